// File: doc/BRIEF.md
# Serial Lane Power-Up Sequencer

This block brings one high-speed serial lane from its reset condition into data mode. A single-cycle start pulse captures the requested lane format (four ports multiplexed on the lane, or a single port), the line speed (1G or 2.5G), the reference clock frequency (125 MHz or 25 MHz) and the transmit-invert, receive-invert and loopback options. From the captured format, speed and reference clock it works out the lane width select, the rate codes, the PLL multiplier and the reference divide-by-2 bit. It then drives the lane control outputs through a fixed, ordered enable sequence.

The waits between stages are counted in clock cycles. Their length comes from a single parameter that gives the number of cycles in one millisecond. After each timed stage the block samples the matching one-bit status input from the analog lane. It finishes either with `seq_done` set, or with `seq_err` holding a code that names the check that failed. Both results are held until the next start pulse. A start pulse at any time clears every enable and runs the whole sequence again.

Top module: `serdes_lane_sequencer`

## Requirements
- R1: While `rst_n` is low and after it rises with no start, `rx_reset`, `tx_reset`, `phy_reset` and `rx_term_en` are 1. Every enable and every configuration field is 0, `seq_done` is 0 and `seq_err` is 0.
- R2: The lane width select `lane_sel_10b` is 0 in quad mode (`cfg_single`=0) and 1 in single mode. Both rate codes are 0 in quad mode. In single mode both rate codes are 1 at 2.5G (`cfg_fast`=1) and 2 at 1G.
- R3: With `cfg_ref125`=1, `ref_div2` is 1 and `pll_mult` is 50 for single mode at 2.5G, otherwise 40. With `cfg_ref125`=0, `ref_div2` is 0 and `pll_mult` is 125 for single mode at 2.5G, otherwise 100.
- R4: Counting clock edges from the edge that samples start as edge 0, the steps happen in this order:
  - edge 1: the lane fields, the invert and loopback bits, and `rx_reset`/`tx_reset` cleared;
  - edge 2: `pll_mult` and `ref_div2`;
  - edge 3: `rx_term_en` cleared;
  - edge 4: `ref_clk_en` set.
- R5: `phy_reset` falls exactly CYC_PER_MS edges after `ref_clk_en` rises. `pll_en` rises exactly CYC_PER_MS edges after that.
- R6: 7*CYC_PER_MS edges after `pll_en` rises, `stat_pll` is sampled. If it is 1, `txcm_en` is set at that edge. If it is 0, `seq_err` becomes 1 and no later enable is set.
- R7: CYC_PER_MS edges after `txcm_en` rises, `stat_cm` is sampled. If it is 1, `rxpll_en` and `tx_en` are set together at that edge. If it is 0, `seq_err` becomes 2.
- R8: CYC_PER_MS edges after `rxpll_en` rises, `stat_rxpll` is checked first (failure code 3) and `stat_tx` second (failure code 4). When both are low the code is 3.
- R9: Only when every check passes, `tx_data_en`, `rx_data_en` and `seq_done` are set together at the last check edge.
- R10: `seq_done` and a nonzero `seq_err` are never set at the same time. Either one, once set, holds with all outputs unchanged until the next start.
- R11: A start pulse in any state returns every output to its reset value at the edge that samples it (with `seq_done` and `seq_err` cleared), then runs the sequence from edge 1.
- R12: The configuration and option inputs are captured only at the start edge. Changes to them after that edge have no effect on the outputs of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, the unit of every wait |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to (re)run the sequence |
| cfg_single | input | 1 | 1 selects single-port format, 0 the quad-port format |
| cfg_fast | input | 1 | 1 selects 2.5G, 0 selects 1G |
| cfg_ref125 | input | 1 | 1 for a 125 MHz reference, 0 for 25 MHz |
| cfg_tx_inv | input | 1 | Requested transmit polarity inversion |
| cfg_rx_inv | input | 1 | Requested receive polarity inversion |
| cfg_loop | input | 1 | Requested transmit-to-receive loopback |
| stat_pll | input | 1 | Main PLL state good |
| stat_cm | input | 1 | Transmit common-mode state good |
| stat_rxpll | input | 1 | Receive PLL state good |
| stat_tx | input | 1 | Transmitter state good |
| lane_sel_10b | output | 1 | Lane 10-bit width select |
| tx_rate | output | 2 | Transmit rate code |
| rx_rate | output | 2 | Receive rate code |
| pll_mult | output | 8 | Main PLL multiplier |
| ref_div2 | output | 1 | Reference divide-by-2 |
| tx_invert | output | 1 | Transmit inversion |
| rx_invert | output | 1 | Receive inversion |
| lane_loopback | output | 1 | Lane loopback enable |
| rx_reset | output | 1 | Receive reset |
| tx_reset | output | 1 | Transmit reset |
| rx_term_en | output | 1 | Receiver termination enable |
| ref_clk_en | output | 1 | Reference clock enable |
| phy_reset | output | 1 | Lane PHY reset |
| pll_en | output | 1 | Main PLL enable |
| txcm_en | output | 1 | Transmit common-mode enable |
| rxpll_en | output | 1 | Receive PLL enable |
| tx_en | output | 1 | Transmitter enable |
| tx_data_en | output | 1 | Transmit data enable |
| rx_data_en | output | 1 | Receive data enable |
| seq_done | output | 1 | Sequence completed |
| seq_err | output | 3 | 0 none, 1 PLL, 2 common mode, 3 receive PLL, 4 transmitter |

## Verification
The hardest situations to reach are the late failures and a restart in the middle of a wait. Each late failure needs every earlier stage to pass, followed by one chosen status line staying low. The bench therefore models each status input as the matching enable gated by a per-stage fault flag. This lets a run fail at any chosen stage, including the case where both final checks fail and the receive PLL code must win. A second start is issued while the PLL wait is still running, and the bench checks that the outputs already set are cleared. The bench also flips the configuration inputs right after every start, so that each of the 64 successful runs also tests capture at the start edge.

// File: rtl/lane_seq_pkg.sv
// Shared types for the lane power-up sequencer.
// Assumes: one lane per instance; the multiplier fits in 8 bits.
package lane_seq_pkg;

    localparam int MULT_W = 8;

    // Failure codes reported on the error output; their values are visible at the top
    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_PLL   = 3'd1,
        ERR_CM    = 3'd2,
        ERR_RXPLL = 3'd3,
        ERR_TX    = 3'd4
    } lane_err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FIELDS,
        ST_MULT,
        ST_TERM,
        ST_REFEN,
        ST_WREF,
        ST_WRST,
        ST_WPLL,
        ST_WCM,
        ST_WLANE,
        ST_DONE,
        ST_FAIL
    } lane_state_e;

    typedef struct packed {
        logic              sel10b;
        logic [1:0]        tx_rate;
        logic [1:0]        rx_rate;
        logic [MULT_W-1:0] mult;
        logic              div2;
    } lane_cfg_t;

    typedef struct packed {
        logic      rx_rst;
        logic      tx_rst;
        logic      phy_rst;
        logic      rx_term;
        logic      ref_en;
        logic      pll_en;
        logic      cm_en;
        logic      rxpll_en;
        logic      tx_en;
        logic      tx_data_en;
        logic      rx_data_en;
        logic      tx_inv;
        logic      rx_inv;
        logic      loopbk;
        lane_cfg_t cfg;
    } lane_ctl_t;

    localparam lane_ctl_t CTL_RESET = '{
        rx_rst: 1'b1, tx_rst: 1'b1, phy_rst: 1'b1, rx_term: 1'b1,
        ref_en: 1'b0, pll_en: 1'b0, cm_en: 1'b0, rxpll_en: 1'b0,
        tx_en: 1'b0, tx_data_en: 1'b0, rx_data_en: 1'b0,
        tx_inv: 1'b0, rx_inv: 1'b0, loopbk: 1'b0, cfg: '0
    };

endpackage

// File: rtl/lane_cfg_calc.sv
// Derives the lane width, rate codes, multiplier and reference divide
// from the captured format, speed and reference clock selects.
// Assumes: pure combinational; its inputs are held stable by the controller.
module lane_cfg_calc
    import lane_seq_pkg::*;
(
    input  logic      single_mode,
    input  logic      fast_speed,
    input  logic      ref_is_125,
    output lane_cfg_t cfg
);

    localparam int MULT_125_BASE = 40;
    localparam int MULT_125_FAST = 50;
    localparam int MULT_25_BASE  = 100;
    localparam int MULT_25_FAST  = 125;

    logic fast_single;
    assign fast_single = single_mode && fast_speed;

    // Map the selects onto the configuration fields
    always_comb begin
        cfg.sel10b  = single_mode;
        cfg.tx_rate = !single_mode ? 2'd0 : (fast_speed ? 2'd1 : 2'd2);
        cfg.rx_rate = cfg.tx_rate;
        cfg.div2    = ref_is_125;
        if (ref_is_125)
            cfg.mult = fast_single ? MULT_W'(MULT_125_FAST) : MULT_W'(MULT_125_BASE);
        else
            cfg.mult = fast_single ? MULT_W'(MULT_25_FAST) : MULT_W'(MULT_25_BASE);
    end

endmodule

// File: rtl/lane_wait_timer.sv
// Down-counter for the timed waits. A load of N raises expired for one
// cycle, N edges after the load edge.
// Assumes: load_val is at least 1; a load takes priority over counting.
module lane_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;
    logic          running;

    // Count down the loaded interval, then stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_val - TW'(1);
            running <= 1'b1;
        end else if (running && cnt != '0) begin
            cnt <= cnt - TW'(1);
        end else begin
            running <= 1'b0;
        end
    end

    assign expired = running && (cnt == '0);

    p_load_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    p_expire_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> !expired);

endmodule

// File: rtl/lane_seq_ctrl.sv
// Ordered enable sequence: applies the fields, runs the timed waits,
// checks each status input and reports done or a stage-specific error.
// Assumes: the status inputs are sampled only when a wait expires.
module lane_seq_ctrl
    import lane_seq_pkg::*;
#(
    parameter int TW       = 8,
    parameter int ONE_MS   = 4,
    parameter int SEVEN_MS = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_single,
    input  logic          cfg_fast,
    input  logic          cfg_ref125,
    input  logic          cfg_tx_inv,
    input  logic          cfg_rx_inv,
    input  logic          cfg_loop,
    input  lane_cfg_t     cfg_in,
    input  logic          stat_pll,
    input  logic          stat_cm,
    input  logic          stat_rxpll,
    input  logic          stat_tx,
    input  logic          tmr_expired,
    output logic [2:0]    sel_q,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output lane_ctl_t     ctl,
    output logic          done,
    output lane_err_e     err
);

    lane_state_e state;
    logic [2:0]  opt_q;

    // Decide when the wait timer is (re)loaded and with which interval
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TW'(ONE_MS);
        case (state)
            ST_REFEN: tmr_load = 1'b1;
            ST_WREF:  tmr_load = tmr_expired;
            ST_WRST: begin
                tmr_load = tmr_expired;
                tmr_val  = TW'(SEVEN_MS);
            end
            ST_WPLL:  tmr_load = tmr_expired && stat_pll;
            ST_WCM:   tmr_load = tmr_expired && stat_cm;
            default:  tmr_load = 1'b0;
        endcase
    end

    // Sequence state and registered lane controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ctl   <= CTL_RESET;
            done  <= 1'b0;
            err   <= ERR_NONE;
            sel_q <= '0;
            opt_q <= '0;
        end else if (start) begin
            state <= ST_FIELDS;
            ctl   <= CTL_RESET;
            done  <= 1'b0;
            err   <= ERR_NONE;
            sel_q <= {cfg_single, cfg_fast, cfg_ref125};
            opt_q <= {cfg_tx_inv, cfg_rx_inv, cfg_loop};
        end else begin
            case (state)
                ST_FIELDS: begin
                    ctl.cfg.sel10b  <= cfg_in.sel10b;
                    ctl.cfg.tx_rate <= cfg_in.tx_rate;
                    ctl.cfg.rx_rate <= cfg_in.rx_rate;
                    ctl.tx_inv      <= opt_q[2];
                    ctl.rx_inv      <= opt_q[1];
                    ctl.loopbk      <= opt_q[0];
                    ctl.rx_rst      <= 1'b0;
                    ctl.tx_rst      <= 1'b0;
                    state           <= ST_MULT;
                end
                ST_MULT: begin
                    ctl.cfg.mult <= cfg_in.mult;
                    ctl.cfg.div2 <= cfg_in.div2;
                    state        <= ST_TERM;
                end
                ST_TERM: begin
                    ctl.rx_term <= 1'b0;
                    state       <= ST_REFEN;
                end
                ST_REFEN: begin
                    ctl.ref_en <= 1'b1;
                    state      <= ST_WREF;
                end
                ST_WREF: if (tmr_expired) begin
                    ctl.phy_rst <= 1'b0;
                    state       <= ST_WRST;
                end
                ST_WRST: if (tmr_expired) begin
                    ctl.pll_en <= 1'b1;
                    state      <= ST_WPLL;
                end
                ST_WPLL: if (tmr_expired) begin
                    if (stat_pll) begin
                        ctl.cm_en <= 1'b1;
                        state     <= ST_WCM;
                    end else begin
                        err   <= ERR_PLL;
                        state <= ST_FAIL;
                    end
                end
                ST_WCM: if (tmr_expired) begin
                    if (stat_cm) begin
                        ctl.rxpll_en <= 1'b1;
                        ctl.tx_en    <= 1'b1;
                        state        <= ST_WLANE;
                    end else begin
                        err   <= ERR_CM;
                        state <= ST_FAIL;
                    end
                end
                ST_WLANE: if (tmr_expired) begin
                    if (!stat_rxpll) begin
                        err   <= ERR_RXPLL;
                        state <= ST_FAIL;
                    end else if (!stat_tx) begin
                        err   <= ERR_TX;
                        state <= ST_FAIL;
                    end else begin
                        ctl.tx_data_en <= 1'b1;
                        ctl.rx_data_en <= 1'b1;
                        done           <= 1'b1;
                        state          <= ST_DONE;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err != ERR_NONE));

    p_err_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err != ERR_NONE && !start) |=> $stable(err) && $stable(ctl));

    p_phy_after_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.phy_rst |-> ctl.ref_en);

    p_cm_needs_pll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.cm_en |-> ctl.pll_en);

    p_lanes_need_cm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rxpll_en |-> ctl.cm_en);

    p_data_after_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.tx_data_en) |-> $past(stat_rxpll && stat_tx));

    p_mult_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pll_en |-> (ctl.cfg.mult == 8'd40 || ctl.cfg.mult == 8'd50 ||
                        ctl.cfg.mult == 8'd100 || ctl.cfg.mult == 8'd125));

    p_restart_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && err == ERR_NONE && !ctl.ref_en && ctl.phy_rst));

endmodule

// File: rtl/serdes_lane_sequencer.sv
// Top of the lane power-up sequencer: the configuration derivation,
// the wait timer and the sequence controller.
// Assumes: CYC_PER_MS is the number of clk cycles in one millisecond.
module serdes_lane_sequencer #(
    parameter int CYC_PER_MS = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cfg_single,
    input  logic       cfg_fast,
    input  logic       cfg_ref125,
    input  logic       cfg_tx_inv,
    input  logic       cfg_rx_inv,
    input  logic       cfg_loop,
    input  logic       stat_pll,
    input  logic       stat_cm,
    input  logic       stat_rxpll,
    input  logic       stat_tx,
    output logic       lane_sel_10b,
    output logic [1:0] tx_rate,
    output logic [1:0] rx_rate,
    output logic [7:0] pll_mult,
    output logic       ref_div2,
    output logic       tx_invert,
    output logic       rx_invert,
    output logic       lane_loopback,
    output logic       rx_reset,
    output logic       tx_reset,
    output logic       rx_term_en,
    output logic       ref_clk_en,
    output logic       phy_reset,
    output logic       pll_en,
    output logic       txcm_en,
    output logic       rxpll_en,
    output logic       tx_en,
    output logic       tx_data_en,
    output logic       rx_data_en,
    output logic       seq_done,
    output logic [2:0] seq_err
);
    import lane_seq_pkg::*;

    localparam int ONE_MS   = CYC_PER_MS;
    localparam int SEVEN_MS = 7 * CYC_PER_MS;
    localparam int TW       = $clog2(SEVEN_MS + 1);

    logic [2:0]    sel_q;
    lane_cfg_t     cfg_calc;
    lane_ctl_t     ctl;
    logic          tmr_load;
    logic          tmr_expired;
    logic [TW-1:0] tmr_val;
    lane_err_e     err;

    lane_cfg_calc u_calc (
        .single_mode (sel_q[2]),
        .fast_speed  (sel_q[1]),
        .ref_is_125  (sel_q[0]),
        .cfg         (cfg_calc)
    );

    lane_wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lane_seq_ctrl #(.TW(TW), .ONE_MS(ONE_MS), .SEVEN_MS(SEVEN_MS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_single  (cfg_single),
        .cfg_fast    (cfg_fast),
        .cfg_ref125  (cfg_ref125),
        .cfg_tx_inv  (cfg_tx_inv),
        .cfg_rx_inv  (cfg_rx_inv),
        .cfg_loop    (cfg_loop),
        .cfg_in      (cfg_calc),
        .stat_pll    (stat_pll),
        .stat_cm     (stat_cm),
        .stat_rxpll  (stat_rxpll),
        .stat_tx     (stat_tx),
        .tmr_expired (tmr_expired),
        .sel_q       (sel_q),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ctl         (ctl),
        .done        (seq_done),
        .err         (err)
    );

    assign lane_sel_10b  = ctl.cfg.sel10b;
    assign tx_rate       = ctl.cfg.tx_rate;
    assign rx_rate       = ctl.cfg.rx_rate;
    assign pll_mult      = ctl.cfg.mult;
    assign ref_div2      = ctl.cfg.div2;
    assign tx_invert     = ctl.tx_inv;
    assign rx_invert     = ctl.rx_inv;
    assign lane_loopback = ctl.loopbk;
    assign rx_reset      = ctl.rx_rst;
    assign tx_reset      = ctl.tx_rst;
    assign rx_term_en    = ctl.rx_term;
    assign ref_clk_en    = ctl.ref_en;
    assign phy_reset     = ctl.phy_rst;
    assign pll_en        = ctl.pll_en;
    assign txcm_en       = ctl.cm_en;
    assign rxpll_en      = ctl.rxpll_en;
    assign tx_en         = ctl.tx_en;
    assign tx_data_en    = ctl.tx_data_en;
    assign rx_data_en    = ctl.rx_data_en;
    assign seq_err       = err;

endmodule

// File: tb/sim_serdes_lane_sequencer.sv
// Self-checking bench: sweeps every configuration and option combination,
// injects a fault at each status stage and restarts in the middle of a wait.
module sim_serdes_lane_sequencer;

    localparam int N  = 6;
    localparam int T0 = 4;
    localparam int LEN = T0 + 11 * N + 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0;
    logic c_single = 0, c_fast = 0, c_ref = 0, c_ti = 0, c_ri = 0, c_lp = 0;
    logic f_pll = 0, f_cm = 0, f_rx = 0, f_tx = 0;

    logic       lane_sel_10b, ref_div2, tx_invert, rx_invert, lane_loopback;
    logic [1:0] tx_rate, rx_rate;
    logic [7:0] pll_mult;
    logic       rx_reset, tx_reset, rx_term_en, ref_clk_en, phy_reset, pll_en;
    logic       txcm_en, rxpll_en, tx_en, tx_data_en, rx_data_en, seq_done;
    logic [2:0] seq_err;
    logic       s_pll, s_cm, s_rx, s_tx;

    // Analog lane model: each status follows its enable unless a fault is injected
    assign s_pll = pll_en   & ~f_pll;
    assign s_cm  = txcm_en  & ~f_cm;
    assign s_rx  = rxpll_en & ~f_rx;
    assign s_tx  = tx_en    & ~f_tx;

    serdes_lane_sequencer #(.CYC_PER_MS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_single(c_single), .cfg_fast(c_fast), .cfg_ref125(c_ref),
        .cfg_tx_inv(c_ti), .cfg_rx_inv(c_ri), .cfg_loop(c_lp),
        .stat_pll(s_pll), .stat_cm(s_cm), .stat_rxpll(s_rx), .stat_tx(s_tx),
        .lane_sel_10b(lane_sel_10b), .tx_rate(tx_rate), .rx_rate(rx_rate),
        .pll_mult(pll_mult), .ref_div2(ref_div2), .tx_invert(tx_invert),
        .rx_invert(rx_invert), .lane_loopback(lane_loopback),
        .rx_reset(rx_reset), .tx_reset(tx_reset), .rx_term_en(rx_term_en),
        .ref_clk_en(ref_clk_en), .phy_reset(phy_reset), .pll_en(pll_en),
        .txcm_en(txcm_en), .rxpll_en(rxpll_en), .tx_en(tx_en),
        .tx_data_en(tx_data_en), .rx_data_en(rx_data_en),
        .seq_done(seq_done), .seq_err(seq_err)
    );

    int checks = 0;
    int errors = 0;
    int t_rst, t_mult, t_term, t_ref, t_phy, t_pll, t_cm, t_rxp, t_txe, t_td, t_rd, t_done, t_err;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Outputs that should sit at their reset values (R1, R11)
    task automatic check_cleared(input string req);
        check({req, " resets"}, {rx_reset, tx_reset, phy_reset, rx_term_en}, 4'hF);
        check({req, " enables"}, {ref_clk_en, pll_en, txcm_en, rxpll_en, tx_en,
                                  tx_data_en, rx_data_en}, 0);
        check({req, " fields"}, {lane_sel_10b, tx_rate, rx_rate, pll_mult, ref_div2,
                                 tx_invert, rx_invert, lane_loopback}, 0);
        check({req, " done/err"}, {seq_done, seq_err}, 0);
    endtask

    task automatic pulse_start(input bit s, f, r, ti, ri, lp);
        @(negedge clk);
        c_single = s; c_fast = f; c_ref = r; c_ti = ti; c_ri = ri; c_lp = lp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R12: flip every captured input right after the start edge
        c_single = ~s; c_fast = ~f; c_ref = ~r; c_ti = ~ti; c_ri = ~ri; c_lp = ~lp;
    endtask

    task automatic mark(inout int t, input logic cond, input int k);
        if (t < 0 && cond) t = k;
    endtask

    task automatic trace(input int len);
        t_rst = -1; t_mult = -1; t_term = -1; t_ref = -1; t_phy = -1; t_pll = -1;
        t_cm = -1; t_rxp = -1; t_txe = -1; t_td = -1; t_rd = -1; t_done = -1; t_err = -1;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            mark(t_rst, !rx_reset && !tx_reset, k);
            mark(t_mult, pll_mult != 0, k);
            mark(t_term, !rx_term_en, k);
            mark(t_ref, ref_clk_en, k);
            mark(t_phy, !phy_reset, k);
            mark(t_pll, pll_en, k);
            mark(t_cm, txcm_en, k);
            mark(t_rxp, rxpll_en, k);
            mark(t_txe, tx_en, k);
            mark(t_td, tx_data_en, k);
            mark(t_rd, rx_data_en, k);
            mark(t_done, seq_done, k);
            mark(t_err, seq_err != 0, k);
        end
    endtask

    // fault: 0 none, 1 pll, 2 common mode, 3 rx pll, 4 tx, 5 rx pll and tx
    task automatic run_case(input bit s, f, r, ti, ri, lp, input int fault);
        int exp_code, exp_terr, exp_mult;
        f_pll = (fault == 1); f_cm = (fault == 2);
        f_rx = (fault == 3 || fault == 5); f_tx = (fault == 4 || fault == 5);
        pulse_start(s, f, r, ti, ri, lp);
        check_cleared("R11 restart");
        trace(LEN);
        check("R4 resets clear edge", t_rst, 1);
        check("R4 mult edge", t_mult, 2);
        check("R4 term edge", t_term, 3);
        check("R4 refclk edge", t_ref, T0);
        check("R5 phy reset release", t_phy, T0 + N);
        check("R5 pll enable", t_pll, T0 + 2 * N);
        check("R6 common mode enable", t_cm, (fault == 1) ? -1 : T0 + 9 * N);
        check("R7 rx pll enable", t_rxp, (fault == 1 || fault == 2) ? -1 : T0 + 10 * N);
        check("R7 tx enable", t_txe, t_rxp);
        check("R9 tx data enable", t_td, (fault == 0) ? T0 + 11 * N : -1);
        check("R9 rx data enable", t_rd, t_td);
        check("R9 done", t_done, t_td);
        exp_code = (fault == 5) ? 3 : fault;
        exp_terr = (fault == 0) ? -1 : (fault == 1) ? T0 + 9 * N :
                   (fault == 2) ? T0 + 10 * N : T0 + 11 * N;
        check("R8 error edge", t_err, exp_terr);
        check("R10 held error code", seq_err, exp_code);
        check("R10 held done", seq_done, (fault == 0));
        // R2 width and rate codes
        check("R2 lane select", lane_sel_10b, s);
        check("R2 tx rate", tx_rate, !s ? 0 : (f ? 1 : 2));
        check("R2 rx rate", rx_rate, !s ? 0 : (f ? 1 : 2));
        // R3 multiplier and divide
        exp_mult = (r ? 40 : 100) * ((s && f) ? 5 : 4) / 4;
        check("R3 multiplier", pll_mult, exp_mult);
        check("R3 ref divide", ref_div2, r);
        // R12 options captured at start despite later input changes
        check("R12 options", {tx_invert, rx_invert, lane_loopback}, {ti, ri, lp});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual 0 expected 1 (run did not finish)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_cleared("R1 in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_cleared("R1 after reset");

        for (int cfg = 0; cfg < 8; cfg++)
            for (int opt = 0; opt < 8; opt++)
                run_case(cfg[2], cfg[1], cfg[0], opt[2], opt[1], opt[0], 0);

        for (int fl = 1; fl <= 5; fl++) begin
            run_case(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, fl);
            run_case(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, fl);
        end

        // R11: restart while the PLL wait is running, then a full clean run
        f_pll = 0; f_cm = 0; f_rx = 0; f_tx = 0;
        pulse_start(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        trace(T0 + 2 * N + 2);
        check("R11 pll was enabled before restart", pll_en, 1);
        run_case(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule